// File: doc/BRIEF.md
# Bi-quinary decade counter with gated preset and clear

This block holds two counting stages that share nothing but their preset and clear logic. The first stage toggles between 0 and 1. The second stage counts modulo five through the states 000, 001, 010, 011 and 100, then returns to 000. Each stage has its own count input. A stage steps once for every high-to-low transition on that input, and the transition is detected against the system clock. The output word packs the two stages together. Bit 0 (A) is the two-state stage. Bits 3..1 (D, C, B) are the five-state stage, with B as its least significant bit.

The stages are joined by wiring outside the block. Feeding A into the five-state input gives a decimal counter whose output follows BCD 0 to 9. Feeding the input pulses to the five-state stage and feeding D into the two-state input gives a divide-by-ten with a square wave on A. A clear acts only when both of its two inputs are high, and it forces the word to 0000. A preset acts only when both of its two inputs are high, and it forces the word to 1001 (nine). Routing output bits back to the clear or preset inputs gives any division ratio from 2 to 9.

Clear and preset are level-sensitive and take effect at the next system clock edge. While either one is active, both stages hold the forced value. Any count transition seen while a force is active is discarded, so a stage whose input is pulled low by the force does not step when the force lifts.

Top module: `biquinary_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `count_q` reads 0000.
- R2: Bit 0 of `count_q` toggles once for each high-to-low transition on `tick_a_in`. The change is visible after the first system clock edge at which the input is sampled low. A low-to-high transition has no effect.
- R3: Each high-to-low transition on `tick_b_in` steps `count_q[3:1]` through 000, 001, 010, 011, 100 and back to 000. The five-state stage never holds any other value.
- R4: When `clr_a` and `clr_b` are both high, `count_q` becomes 0000 at the next clock edge. Either input high on its own changes nothing.
- R5: When `pre_a` and `pre_b` are both high, `count_q` becomes 1001 at the next clock edge. Either input high on its own changes nothing.
- R6: When preset and clear are active together, the preset wins and `count_q` becomes 1001.
- R7: While a clear or a preset is active, neither stage counts. Transitions on the count inputs during that time are ignored.
- R8: With the input pulses on `tick_a_in` and bit 0 fed to `tick_b_in`, `count_q` follows BCD 0 to 9 and then wraps. Bit 3 is high for 2 of every 10 input pulses.
- R9: With the input pulses on `tick_b_in` and bit 3 fed to `tick_a_in`, bit 0 repeats every 10 input pulses and is high for 5 of them. The five-state stage holds (pulses mod 5), and bit 0 holds ((pulses / 5) mod 2).
- R10: Feedback from the outputs gives the ratios 2 to 9, as follows:
  - 2: the two-state stage alone.
  - 3: the five-state stage alone, with B and C driving the clear.
  - 4: the five-state stage alone, with 1 and D driving the clear.
  - 5: the five-state stage alone.
  - 6: the chained stages, with B and C driving the clear.
  - 7: the chained stages, with B and C driving the preset. The count jumps to 9 on the sixth pulse and returns to 0 on the seventh.
  - 8: the chained stages, with 1 and D driving the clear.
  - 9: the chained stages, with A and D driving the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_a_in | input | 1 | Count input of the two-state stage; steps on its falling transition |
| tick_b_in | input | 1 | Count input of the five-state stage; steps on its falling transition |
| clr_a | input | 1 | First input of the clear gate |
| clr_b | input | 1 | Second input of the clear gate |
| pre_a | input | 1 | First input of the preset gate |
| pre_b | input | 1 | Second input of the preset gate |
| count_q | output | 4 | Count word: bit 0 = A, bits 3..1 = D C B of the five-state stage |

## Verification
On every cycle, the embedded assertions check the following: the five-state stage stays in range, each stage steps or holds exactly as its detected transition and the force inputs dictate, and a preset or clear always lands on its forced value with the preset winning. Only the bench scenarios can show the properties that depend on external wiring. These are the BCD sequence, the 2:8 and 5:5 duty patterns of the two decade arrangements, and each feedback ratio from 2 to 9, including the jump to nine in the divide-by-7 arrangement. The bench also checks that a single input of either gate has no effect, and that rising transitions are ignored, by reading `count_q` after the stimulus.

// File: rtl/biq_pkg.sv
package biq_pkg;

  // Default modulus of the second counting stage.
  localparam int unsigned BIQ_QUINARY_MOD = 5;

  // Decoded force request shared by both stages.
  typedef struct packed {
    logic preset;
    logic clear;
  } biq_force_t;

endpackage

// File: rtl/biq_rst_sync.sv
module biq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/biq_fall_det.sv
module biq_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic squash,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  // A forced cycle forgets the input history, so any transition
  // produced by the force itself is never seen as a count step.
  always_comb begin
    prev_d = sig_in;
    if (squash) begin
      prev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sig_in;

endmodule

// File: rtl/biq_mod_stage.sv
module biq_mod_stage
  import biq_pkg::*;
#(
  parameter int unsigned MOD = 5,
  localparam int unsigned W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  biq_force_t force_in,
  output logic [W-1:0] state_o
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         state_en;

  // Preset loads the top state, clear loads zero, preset wins.
  always_comb begin
    state_en = force_in.preset | force_in.clear | step;
    state_d  = state_q;
    if (force_in.preset) begin
      state_d = LAST;
    end else if (force_in.clear) begin
      state_d = '0;
    end else if (step) begin
      state_d = (state_q == LAST) ? '0 : state_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= LAST);

  // R2 R3
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !force_in.preset && !force_in.clear) |=>
      (state_q == (($past(state_q) == LAST) ? '0 : $past(state_q) + 1'b1)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !force_in.preset && !force_in.clear) |=> $stable(state_q));

  // R6
  preset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_in.preset |=> (state_q == LAST));

endmodule

// File: rtl/biquinary_counter.sv
module biquinary_counter
  import biq_pkg::*;
#(
  parameter int unsigned QUINARY_MOD = BIQ_QUINARY_MOD,
  parameter int          SYNC_STAGES = 2,
  localparam int unsigned Q_W   = (QUINARY_MOD > 1) ? $clog2(QUINARY_MOD) : 1,
  localparam int unsigned CNT_W = Q_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_a_in,
  input  logic             tick_b_in,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             pre_a,
  input  logic             pre_b,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [Q_W-1:0]   Q_LAST = Q_W'(QUINARY_MOD - 1);
  localparam logic [CNT_W-1:0] PRESET_WORD = {Q_LAST, 1'b1};

  logic       rst_sync_n;
  biq_force_t force_req;
  logic       force_any;
  logic       fall_a;
  logic       fall_b;
  logic [0:0]     bin_state;
  logic [Q_W-1:0] quin_state;

  biq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Two-input AND gates in front of the shared force lines.
  always_comb begin
    force_req.clear  = clr_a & clr_b;
    force_req.preset = pre_a & pre_b;
    force_any        = force_req.clear | force_req.preset;
  end

  biq_fall_det u_fall_a (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_in (tick_a_in),
    .squash (force_any),
    .fall_o (fall_a)
  );

  biq_fall_det u_fall_b (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_in (tick_b_in),
    .squash (force_any),
    .fall_o (fall_b)
  );

  biq_mod_stage #(.MOD(2)) u_bin_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (fall_a),
    .force_in (force_req),
    .state_o  (bin_state)
  );

  biq_mod_stage #(.MOD(QUINARY_MOD)) u_quin_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (fall_b),
    .force_in (force_req),
    .state_o  (quin_state)
  );

  assign count_q = {quin_state, bin_state};

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_a && clr_b && !(pre_a && pre_b)) |=> (count_q == '0));

  // R5 R6
  preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pre_a && pre_b) |=> (count_q == PRESET_WORD));

  // R4 R5 R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(clr_a && clr_b) && !(pre_a && pre_b) && !fall_a && !fall_b)
      |=> $stable(count_q));

endmodule

// File: tb/biquinary_counter_tb.sv
module biquinary_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_a, tick_b, c_a, c_b, p_a, p_b;
  logic [3:0] count_q;

  // bench-side stimulus and wiring choice
  int   cfg;  // 0 manual, 1 symmetric, 2..9 feedback ratio, 10 plain BCD
  logic fin, t2, t5, m_ca, m_cb, m_pa, m_pb;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  biquinary_counter u_dut (
    .clk (clk), .rst_n (rst_n), .tick_a_in (tick_a), .tick_b_in (tick_b),
    .clr_a (c_a), .clr_b (c_b), .pre_a (p_a), .pre_b (p_b), .count_q (count_q)
  );

  // External wiring of the chosen arrangement.
  always_comb begin
    tick_a = 1'b0; tick_b = 1'b0; c_a = 1'b0; c_b = 1'b0; p_a = 1'b0; p_b = 1'b0;
    case (cfg)
      0: begin tick_a = t2; tick_b = t5; c_a = m_ca; c_b = m_cb; p_a = m_pa; p_b = m_pb; end
      1: begin tick_b = fin; tick_a = count_q[3]; end
      2: tick_a = fin;
      3: begin tick_b = fin; c_a = count_q[1]; c_b = count_q[2]; end
      4: begin tick_b = fin; c_a = 1'b1; c_b = count_q[3]; end
      5: tick_b = fin;
      6: begin tick_a = fin; tick_b = count_q[0]; c_a = count_q[1]; c_b = count_q[2]; end
      7: begin tick_a = fin; tick_b = count_q[0]; p_a = count_q[1]; p_b = count_q[2]; end
      8: begin tick_a = fin; tick_b = count_q[0]; c_a = 1'b1; c_b = count_q[3]; end
      9: begin tick_a = fin; tick_b = count_q[0]; c_a = count_q[0]; c_b = count_q[3]; end
      default: begin tick_a = fin; tick_b = count_q[0]; end
    endcase
  end

  // Behavioural expectation after k input pulses in arrangement c.
  function automatic logic [3:0] model(int c, int k);
    int m;
    if (c == 1) return 4'(((k % 5) * 2) + ((k / 5) % 2));
    if (c == 2) return 4'(k % 2);
    if (c >= 3 && c <= 5) return 4'((k % c) * 2);
    if (c == 7) begin
      m = k % 7;
      return (m == 6) ? 4'd9 : 4'(m);
    end
    return 4'(k % c);
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count_q=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 pulse source, 1 two-state input, 2 five-state input
  task automatic pulse(input int which);
    if (which == 0) fin = 1'b1; else if (which == 1) t2 = 1'b1; else t5 = 1'b1;
    wait_n(3);
    if (which == 0) fin = 1'b0; else if (which == 1) t2 = 1'b0; else t5 = 1'b0;
    wait_n(4);
  endtask

  task automatic restart(input int c);
    rst_n = 1'b0;
    cfg = c;
    fin = 0; t2 = 0; t5 = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic run_cfg(input int c, input int n, input string req, output int hi_d, output int hi_a);
    logic [3:0] e;
    hi_d = 0; hi_a = 0;
    restart(c);
    for (int k = 1; k <= n; k++) begin
      pulse(0);
      e = model(c, k);
      chk(count_q, e, req);
      if (count_q[3]) hi_d++;
      if (count_q[0]) hi_a++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hd, ha;
    rst_n = 1'b0;
    cfg = 0;
    fin = 0; t2 = 0; t5 = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
    wait_n(3);
    chk(count_q, 4'b0000, "R1 during reset");
    rst_n = 1'b1;
    wait_n(4);
    chk(count_q, 4'b0000, "R1 after release");

    // R2: rising edge ignored, falling edge toggles
    t2 = 1'b1; wait_n(4);
    chk(count_q, 4'b0000, "R2 rising ignored");
    t2 = 1'b0; wait_n(4);
    chk(count_q, 4'b0001, "R2 falling toggles");
    pulse(1);
    chk(count_q, 4'b0000, "R2 second toggle");

    // R3: five-state sequence and wrap
    for (int k = 1; k <= 5; k++) begin
      pulse(2);
      chk(count_q, 4'((k % 5) * 2), "R3 quinary step");
    end
    pulse(2); pulse(2);
    chk(count_q, 4'b0100, "R3 state two");

    // R4: single clear input does nothing, both clear
    m_ca = 1'b1; wait_n(3);
    chk(count_q, 4'b0100, "R4 single clear input");
    m_cb = 1'b1; wait_n(3);
    chk(count_q, 4'b0000, "R4 gated clear");
    // R7: counting blocked while clear held
    pulse(2); pulse(1);
    chk(count_q, 4'b0000, "R7 edges ignored under clear");
    m_ca = 1'b0; m_cb = 1'b0; wait_n(3);

    // R5: single preset input does nothing, both preset
    m_pb = 1'b1; wait_n(3);
    chk(count_q, 4'b0000, "R5 single preset input");
    m_pa = 1'b1; wait_n(3);
    chk(count_q, 4'b1001, "R5 gated preset");
    // R6: preset over clear
    m_ca = 1'b1; m_cb = 1'b1; wait_n(3);
    chk(count_q, 4'b1001, "R6 preset wins");
    m_ca = 1'b0; m_cb = 1'b0; m_pa = 1'b0; m_pb = 1'b0; wait_n(3);
    chk(count_q, 4'b1001, "R6 value held after release");
    pulse(1);
    chk(count_q, 4'b1000, "R2 toggle from preset");

    // R8: BCD chain and 2:8 pattern on D
    run_cfg(10, 20, "R8 BCD sequence", hd, ha);
    checks++;
    if (hd != 4) begin errors++; $display("FAIL R8 D high pulses=%0d expected 4", hd); end

    // R9: symmetric division, 5 of 10 high on A
    run_cfg(1, 20, "R9 symmetric sequence", hd, ha);
    checks++;
    if (ha != 10) begin errors++; $display("FAIL R9 A high pulses=%0d expected 10", ha); end

    // R10: feedback ratios 2..9
    for (int n = 2; n <= 9; n++) begin
      run_cfg(n, 2 * n + 1, "R10 feedback ratio", hd, ha);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule